// File: doc/BRIEF.md
# Synchronous Aligned Clock Divider

This block takes a single input clock and produces two divided clocks that share their rising edges. One runs at half the input rate. The other runs at a quarter or a sixth of the input rate, depending on a select input. Both are generated from one shared phase counter, so each rising edge of the slow output falls on a rising edge of the half-rate output. A one-cycle phase marker flags every input cycle in which both divided outputs rise together. Other logic can use it to line up with the divided clocks.

A stop input freezes both outputs at their current levels. It is captured on the falling edge of the input clock, so a start or stop always lands between two rising edges and never cuts a phase short. An asynchronous master reset drives every divided output low and clears the counter, which lets several instances be brought into step. Each divided output also has an inverted copy.

The design is written as a single clock domain. The sampled stop signal acts as a count enable and does not gate the clock.

Top module: `aligned_clkdiv`

## Requirements
- R1: While advancing, `half_o` toggles on every rising input edge, so it has a period of 2 input cycles with 1 high and 1 low.
- R2: With `sel6_i`=0, `slow_o` has a period of 4 advancing cycles (2 high, 2 low). With `sel6_i`=1, it has a period of 6 advancing cycles (3 high, 3 low).
- R3: Every rising edge of `slow_o` occurs on the same input edge as a rising edge of `half_o`.
- R4: `stop_i` is captured only on the falling input edge. A change first acts on the rising edge that follows the next falling edge.
- R5: While the captured stop is 1, `half_o` and `slow_o` hold their levels and `phase_o` is 0. When it returns to 0, division resumes from the held position.
- R6: `mreset_i`=1 forces `half_o`, `slow_o` and `phase_o` low at once, without waiting for a clock edge, and clears the counter and the captured stop.
- R7: After `mreset_i` is released, the first advancing rising edge raises `half_o`, `slow_o` and `phase_o` together.
- R8: `phase_o` is 1 for exactly one input cycle after each edge where `half_o` and `slow_o` both rise. It is 0 in all other cycles, giving one pulse every 4 or 6 advancing cycles.
- R9: `half_n_o` and `slow_n_o` are always the inverses of `half_o` and `slow_o`.
- R10: `sel6_i` is sampled only on the advancing edge where `slow_o` rises. A change made in mid-period leaves the current period length unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| mreset_i | input | 1 | Asynchronous master reset, active high |
| stop_i | input | 1 | 1 holds the outputs; captured on the falling edge |
| sel6_i | input | 1 | Slow-output ratio select: 0 selects divide by 4, 1 selects divide by 6 |
| half_o | output | 1 | Input clock divided by 2 |
| half_n_o | output | 1 | Inverse of half_o |
| slow_o | output | 1 | Input clock divided by 4 or 6 |
| slow_n_o | output | 1 | Inverse of slow_o |
| phase_o | output | 1 | One-cycle pulse marking a shared rising edge |

## Verification
Two pairs of functions can land on the same cycle, and both pairs are tested.

- **Stop and phase pulse.** A stop is captured on the falling edge just before the cycle in which a phase pulse would continue. The pulse must end after one cycle while the divided levels stay frozen.
- **Ratio change and slow rising edge.** `sel6_i` is flipped partway through a divide-by-6 period and kept there through the next rising boundary. The bench expects the old period to finish intact and the new ratio to start exactly at the shared rising edge.

Both cases are judged against a hand-derived per-cycle table of the three outputs.

// File: rtl/aligned_clkdiv_pkg.sv
package aligned_clkdiv_pkg;
  // ratio choice for the slow output
  typedef enum logic {RATIO_LO = 1'b0, RATIO_HI = 1'b1} ratio_e;
endpackage

// File: rtl/stop_sampler.sv
module stop_sampler (
  input  logic clk_i,
  input  logic mreset_i,
  input  logic stop_i,
  output logic adv_o
);
  logic stop_q;

  // captured on the falling edge so a start/stop lands while the clock is low
  always_ff @(negedge clk_i or posedge mreset_i) begin
    if (mreset_i) stop_q <= 1'b0;
    else          stop_q <= stop_i;
  end

  assign adv_o = ~stop_q;
endmodule

// File: rtl/phase_counter.sv
module phase_counter
  import aligned_clkdiv_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6,
  localparam int CNT_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1
) (
  input  logic             clk_i,
  input  logic             mreset_i,
  input  logic             adv_i,
  input  logic             sel6_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic [CNT_W-1:0] high_len_o
);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(DIV_LO - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(DIV_HI - 1);
  localparam logic [CNT_W-1:0] HALF_LO = CNT_W'(DIV_LO / 2);
  localparam logic [CNT_W-1:0] HALF_HI = CNT_W'(DIV_HI / 2);

  logic [CNT_W-1:0] cnt_q;
  ratio_e           ratio_q;
  ratio_e           ratio_eff;
  logic [CNT_W-1:0] last;

  // the ratio is only re-read at the boundary where the slow output rises
  always_comb begin
    ratio_eff  = (cnt_q == '0) ? ratio_e'(sel6_i) : ratio_q;
    last       = (ratio_eff == RATIO_HI) ? LAST_HI : LAST_LO;
    high_len_o = (ratio_eff == RATIO_HI) ? HALF_HI : HALF_LO;
    cnt_nxt_o  = (cnt_q == last) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or posedge mreset_i) begin
    if (mreset_i) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_LO;
    end else if (adv_i) begin
      cnt_q   <= cnt_nxt_o;
      ratio_q <= ratio_eff;
    end
  end

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (mreset_i)
    cnt_q <= LAST_HI);
  assert_ratio_hold_R10: assert property (@(posedge clk_i) disable iff (mreset_i)
    (cnt_q != '0) |=> $stable(ratio_q));
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             mreset_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] high_len_i,
  output logic             half_o,
  output logic             half_n_o,
  output logic             slow_o,
  output logic             slow_n_o,
  output logic             phase_o
);
  localparam int NPAIR = 2;

  logic half_q, slow_q, phase_q;
  logic [NPAIR-1:0] true_v, comp_v;

  always_ff @(posedge clk_i or posedge mreset_i) begin
    if (mreset_i) begin
      half_q  <= 1'b0;
      slow_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (adv_i) begin
      half_q  <= cnt_nxt_i[0];
      slow_q  <= (cnt_nxt_i != '0) && (cnt_nxt_i <= high_len_i);
      phase_q <= (cnt_nxt_i == CNT_W'(1));
    end else begin
      phase_q <= 1'b0;
    end
  end

  assign true_v = {slow_q, half_q};

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    assign comp_v[g] = ~true_v[g];
  end

  assign half_o   = half_q;
  assign slow_o   = slow_q;
  assign half_n_o = comp_v[0];
  assign slow_n_o = comp_v[1];
  assign phase_o  = phase_q;

  assert_half_toggle_R1: assert property (@(posedge clk_i) disable iff (mreset_i)
    adv_i |=> (half_q != $past(half_q)));
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (mreset_i)
    !adv_i |=> ($stable(half_q) && $stable(slow_q) && !phase_q));
  assert_aligned_rise_R3: assert property (@(posedge clk_i) disable iff (mreset_i)
    $rose(slow_q) |-> $rose(half_q));
  assert_phase_width_R8: assert property (@(posedge clk_i) disable iff (mreset_i)
    phase_q |=> !phase_q);
  assert_phase_levels_R8: assert property (@(posedge clk_i) disable iff (mreset_i)
    phase_q |-> (half_q && slow_q));
endmodule

// File: rtl/aligned_clkdiv.sv
module aligned_clkdiv #(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 6
) (
  input  logic clk_i,
  input  logic mreset_i,
  input  logic stop_i,
  input  logic sel6_i,
  output logic half_o,
  output logic half_n_o,
  output logic slow_o,
  output logic slow_n_o,
  output logic phase_o
);
  localparam int CNT_W = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;

  logic             adv;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] high_len;

  stop_sampler u_stop (
    .clk_i    (clk_i),
    .mreset_i (mreset_i),
    .stop_i   (stop_i),
    .adv_o    (adv)
  );

  phase_counter #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_cnt (
    .clk_i      (clk_i),
    .mreset_i   (mreset_i),
    .adv_i      (adv),
    .sel6_i     (sel6_i),
    .cnt_nxt_o  (cnt_nxt),
    .high_len_o (high_len)
  );

  out_stage #(.CNT_W(CNT_W)) u_out (
    .clk_i      (clk_i),
    .mreset_i   (mreset_i),
    .adv_i      (adv),
    .cnt_nxt_i  (cnt_nxt),
    .high_len_i (high_len),
    .half_o     (half_o),
    .half_n_o   (half_n_o),
    .slow_o     (slow_o),
    .slow_n_o   (slow_n_o),
    .phase_o    (phase_o)
  );
endmodule

// File: tb/sim_aligned_clkdiv.sv
module sim_aligned_clkdiv;
  logic clk = 1'b0;
  logic mreset, stop, sel6;
  logic half, half_n, slow, slow_n, phase;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  aligned_clkdiv u0 (
    .clk_i(clk), .mreset_i(mreset), .stop_i(stop), .sel6_i(sel6),
    .half_o(half), .half_n_o(half_n), .slow_o(slow), .slow_n_o(slow_n),
    .phase_o(phase)
  );

  // {sel6, stop, exp_half, exp_slow, exp_phase}
  localparam int NV = 28;
  localparam logic [4:0] VEC [NV] = '{
    5'b00_111, 5'b00_010, 5'b00_100, 5'b00_000, 5'b00_111,
    5'b01_110, 5'b01_110, 5'b00_010, 5'b00_100, 5'b00_000,
    5'b10_111, 5'b10_010, 5'b10_110, 5'b10_000, 5'b10_100,
    5'b10_000, 5'b10_111, 5'b00_010, 5'b00_110, 5'b00_000,
    5'b00_100, 5'b00_000, 5'b00_111, 5'b00_010, 5'b00_100,
    5'b00_000, 5'b01_000, 5'b00_111
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got h/s/p=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_comp(input string req);
    n_chk++;
    if (half_n !== ~half || slow_n !== ~slow) begin
      n_bad++;
      $display("FAIL %s: got n=%b%b expected %b%b", req, half_n, slow_n, ~half, ~slow);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_edge();
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hi_h, hi_s, np;
    mreset = 1'b1; stop = 1'b0; sel6 = 1'b0;
    repeat (3) next_edge();
    // R6 reset state
    check("R6 reset state", {half, slow, phase}, 3'b000);
    check_comp("R9 complements in reset");
    mreset = 1'b0;

    // table walk: covers R1 R2 R3 R5 R7 R8 R10
    for (int i = 0; i < NV; i++) begin
      sel6 = VEC[i][4];
      stop = VEC[i][3];
      next_edge();
      check("R1/R2/R5/R8/R10 vector", {half, slow, phase}, VEC[i][2:0]);
      check_comp("R9 vector complement");
    end
    stop = 1'b0; sel6 = 1'b0;
    // now at k=1 with div4; R4: raise stop after the falling edge
    @(negedge clk); #2 stop = 1'b1;
    next_edge();
    check("R4 late stop still advances", {half, slow, phase}, 3'b010);
    next_edge();
    check("R4 stop acts after next falling edge", {half, slow, phase}, 3'b010);
    stop = 1'b0;
    next_edge();
    check("R5 resume from held position", {half, slow, phase}, 3'b100);

    // R6 asynchronous reset while half is high
    #3 mreset = 1'b1;
    #1;
    check("R6 async reset clears outputs", {half, slow, phase}, 3'b000);
    check_comp("R9 complement after reset");
    next_edge();
    check("R6 reset held", {half, slow, phase}, 3'b000);
    mreset = 1'b0;
    sel6 = 1'b1;
    next_edge();
    check("R7 first edge after reset", {half, slow, phase}, 3'b111);

    // R2/R8 divide-by-6 duty and pulse spacing over 60 cycles
    hi_h = 0; hi_s = 0; np = 0;
    for (int c = 0; c < 60; c++) begin
      next_edge();
      hi_h += int'(half);
      hi_s += int'(slow);
      np   += int'(phase);
    end
    check_int("R1 half duty over 60", hi_h, 30);
    check_int("R2 div6 slow high count", hi_s, 30);
    check_int("R8 div6 phase pulses", np, 10);

    // R2/R8 divide-by-4 over 60 cycles after switching at a boundary
    sel6 = 1'b0;
    repeat (6) next_edge();
    hi_s = 0; np = 0;
    for (int c = 0; c < 60; c++) begin
      next_edge();
      hi_s += int'(slow);
      np   += int'(phase);
    end
    check_int("R2 div4 slow high count", hi_s, 30);
    check_int("R8 div4 phase pulses", np, 15);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule